// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a fast oscillator clock by a programmable fixed-point ratio and emits one single-cycle feedback pulse at the end of every division period. A phase comparator can then compare that pulse against a reference. The ratio word is 19 bits wide and is read as a value over 16384. Its upper 5 bits are the integer part and its lower 14 bits are the fraction. Division periods are either the integer part or the integer part plus one cycles long. A 14-bit phase accumulator chooses between the two, so the long-term average ratio equals the programmed value exactly.

A new ratio word is offered with a one-cycle load strobe. A legal word is parked in a pending slot and becomes active only at the next period boundary, so a period in progress is never cut short. A word below 55706 is refused and flags a one-cycle rejection. 55706 is 3.4 × 16384 rounded up.

Internally a two-state machine sequences the counter. ST_PRIME lasts one cycle after reset and loads the first period, then passes unconditionally to ST_RUN. ST_RUN counts down and stays in ST_RUN. At its terminal count it emits the pulse, takes the pending word if there is one, steps the accumulator and reloads the counter.

Top module: `fracn_fb_divider`

## Requirements
- R1: After rst_n is released the accumulator is zero and the active word is 65536 (ratio 4.0). One priming cycle is followed by the first period, so fb_pulse is first high in the 5th cycle after release, then every 4 cycles. fb_pulse and ratio_reject are low during reset.
- R2: The ratio is the word divided by 16384: bits [18:14] are the integer part and bits [13:0] the fraction. Word 348160 gives 21.25, so any 4 consecutive periods total 85 cycles.
- R3: fb_pulse is high for exactly one cycle per period, in the period's last cycle. Every period is N or N+1 cycles long, where N is the integer part of the active word.
- R4: At each boundary the fraction is added to a 14-bit accumulator. The next period is N+1 cycles when that addition carries past 16383, and N cycles otherwise.
- R5: With a constant word W, any 16384 consecutive periods total exactly W cycles. For example, 87040 (ratio 5.3125) gives 87040 cycles.
- R6: A legal word presented with ratio_load becomes active at the first boundary after the load cycle. A load in the same cycle as fb_pulse therefore leaves the period that starts there on the old word, and the new word governs the period after it.
- R7: A word below 55706 raises ratio_reject in the cycle after the load and has no effect on any period. Word 55706 is accepted, and ratio_reject stays low for it.
- R8: The all-ones word 524287 is legal and gives periods of 31 or 32 cycles, nearly all of them 32.
- R9: If several legal words are loaded within one period, only the last one is applied at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_word | input | 19 | Ratio word, value/16384 |
| ratio_load | input | 1 | One-cycle strobe offering ratio_word |
| fb_pulse | output | 1 | Single-cycle pulse ending each division period |
| ratio_reject | output | 1 | One-cycle flag: last offered word below 55706 |

## Verification
Two events can fall in the same cycle: a ratio load and a period boundary. The bench times a load to coincide with the cycle in which fb_pulse is high. It confirms that the pulse really is high in that cycle. It then judges the next measured period, which must follow the old word, and the one after it, which must follow the new word. Random loads at random gaps hit this coincidence repeatedly, and a bench-side model of the boundary and accumulator rules predicts every period length.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } div_state_e;
endpackage

// File: rtl/fracn_ratio_reg.sv
module fracn_ratio_reg #(
    parameter int RATIO_W    = 19,
    parameter int MIN_WORD   = 55706,
    parameter int RESET_WORD = 65536
) (
    input  logic               clk_osc,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] word_in,
    input  logic               load_in,
    input  logic               take_in,
    output logic [RATIO_W-1:0] next_word,
    output logic               reject_out
);
    localparam logic [RATIO_W-1:0] MIN_L = RATIO_W'(MIN_WORD);
    localparam logic [RATIO_W-1:0] RST_L = RATIO_W'(RESET_WORD);

    logic [RATIO_W-1:0] act_q;
    logic [RATIO_W-1:0] pend_q;
    logic               pend_v_q;
    logic               word_ok;

    assign word_ok   = (word_in >= MIN_L);
    assign next_word = pend_v_q ? pend_q : act_q;

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            act_q      <= RST_L;
            pend_q     <= '0;
            pend_v_q   <= 1'b0;
            reject_out <= 1'b0;
        end else begin
            reject_out <= load_in && !word_ok;
            if (take_in) begin
                act_q <= next_word;
            end
            if (load_in && word_ok) begin
                pend_q   <= word_in;
                pend_v_q <= 1'b1;
            end else if (take_in) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    // R7: a refused word leaves the pending slot untouched
    p_reject_keeps_pending_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (load_in && !word_ok) |=> (pend_q == $past(pend_q)));

    // R6: the active word only moves at a boundary
    p_active_holds_r6: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !take_in |=> (act_q == $past(act_q)));

    // R6: a pending word becomes active at the boundary
    p_pending_applied_r6: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (take_in && pend_v_q) |=> (act_q == $past(pend_q)));
endmodule

// File: rtl/fracn_phase_acc.sv
module fracn_phase_acc #(
    parameter int FRAC_W = 14
) (
    input  logic              clk_osc,
    input  logic              rst_n,
    input  logic              step_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              carry_out
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum_w;

    assign sum_w     = {1'b0, acc_q} + {1'b0, frac_in};
    assign carry_out = sum_w[FRAC_W];

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step_in) begin
            acc_q <= sum_w[FRAC_W-1:0];
        end
    end

    // R4: the accumulator only moves on a boundary step
    p_acc_steady_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !step_in |=> $stable(acc_q));
endmodule

// File: rtl/fracn_mod_counter.sv
module fracn_mod_counter
    import fracn_pkg::*;
#(
    parameter int INT_W = 5
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic [INT_W-1:0] int_in,
    input  logic             carry_in,
    output logic             take_out,
    output logic             pulse_out
);
    localparam int CNT_W = INT_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << INT_W);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_w;

    assign len_w = CNT_W'(int_in) + CNT_W'(carry_in);

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        take_out  = 1'b0;
        pulse_out = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                take_out = 1'b1;
                cnt_d    = len_w;
                state_d  = ST_RUN;
            end
            ST_RUN: begin
                if (cnt_q == CNT_ONE) begin
                    take_out  = 1'b1;
                    pulse_out = 1'b1;
                    cnt_d     = len_w;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            default: state_d = ST_PRIME;
        endcase
    end

    // R3: the feedback pulse never lasts two cycles
    p_pulse_single_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        pulse_out |=> !pulse_out);

    // R3: a running counter never sits at zero
    p_count_live_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q != '0));

    // R1: priming lasts exactly one cycle
    p_prime_once_r1: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (state_q == ST_PRIME) |=> (state_q == ST_RUN));

    // R3: every loaded period lies within the legal modulus span
    p_len_bounds_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        take_out |=> (cnt_q >= CNT_W'(3) && cnt_q <= CNT_MAX));
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider #(
    parameter int INT_W      = 5,
    parameter int FRAC_W     = 14,
    parameter int MIN_WORD   = 55706,
    parameter int RESET_WORD = 65536
) (
    input  logic                    clk_osc,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] ratio_word,
    input  logic                    ratio_load,
    output logic                    fb_pulse,
    output logic                    ratio_reject
);
    localparam int RATIO_W = INT_W + FRAC_W;

    logic [RATIO_W-1:0] sel_word;
    logic               take_w;
    logic               carry_w;

    fracn_ratio_reg #(
        .RATIO_W   (RATIO_W),
        .MIN_WORD  (MIN_WORD),
        .RESET_WORD(RESET_WORD)
    ) u_ratio (
        .clk_osc   (clk_osc),
        .rst_n     (rst_n),
        .word_in   (ratio_word),
        .load_in   (ratio_load),
        .take_in   (take_w),
        .next_word (sel_word),
        .reject_out(ratio_reject)
    );

    fracn_phase_acc #(
        .FRAC_W(FRAC_W)
    ) u_acc (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .step_in  (take_w),
        .frac_in  (sel_word[FRAC_W-1:0]),
        .carry_out(carry_w)
    );

    fracn_mod_counter #(
        .INT_W(INT_W)
    ) u_cnt (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .int_in   (sel_word[RATIO_W-1:FRAC_W]),
        .carry_in (carry_w),
        .take_out (take_w),
        .pulse_out(fb_pulse)
    );
endmodule

// File: tb/fracn_fb_divider_tb_top.sv
`timescale 1ns/1ps
module fracn_fb_divider_tb_top;
    localparam int MIN_W   = 55706;  // 3.4 * 16384 = 55705.6, rounded up
    localparam int RESET_W = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ratio_load = 1'b0;
    logic [18:0] ratio_word = '0;
    logic        fb_pulse;
    logic        ratio_reject;

    always #2.5 clk = ~clk;

    fracn_fb_divider dut_i (
        .clk_osc(clk), .rst_n(rst_n), .ratio_word(ratio_word),
        .ratio_load(ratio_load), .fb_pulse(fb_pulse), .ratio_reject(ratio_reject)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [18:0] m_act, m_pend;
    bit   m_pv, m_started, exp_rej;
    int   m_acc, exp_len, since, last_len, max_len;
    bit   win_arm, win_on, win_done;
    int   win_n, win_target, win_cyc, win_p;
    string win_tag;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_len(input logic [18:0] w, input int acc);
        return int'(w[18:14]) + (((acc + int'(w[13:0])) >= 16384) ? 1 : 0);
    endfunction

    task automatic boundary_step();
        logic [18:0] sel;
        sel     = m_pv ? m_pend : m_act;
        m_act   = sel;
        m_pv    = 1'b0;
        exp_len = next_len(sel, m_acc);
        m_acc   = (m_acc + int'(sel[13:0])) % 16384;
    endtask

    // Reference model and per-period checks (R3, R4, R6, R7)
    always @(negedge clk) begin
        if (!rst_n) begin
            m_act = 19'(RESET_W); m_pv = 1'b0; m_acc = 0;
            m_started = 1'b0; exp_rej = 1'b0; since = 0;
        end else if (!m_started) begin
            boundary_step();
            m_started = 1'b1;
            since = 0;
        end else begin
            since++;
            if (win_on) win_cyc++;
            if (exp_rej || ratio_reject)
                chk(ratio_reject == exp_rej, "R7 reject flag", int'(ratio_reject), int'(exp_rej));
            exp_rej = ratio_load && (int'(ratio_word) < MIN_W);
            if (fb_pulse) begin
                chk(since == exp_len, "R3 R4 R6 period length", since, exp_len);
                last_len = since;
                if (since > max_len) max_len = since;
                since = 0;
                boundary_step();
                if (win_on) begin
                    win_p++;
                    if (win_p == win_n) begin
                        chk(win_cyc == win_target, win_tag, win_cyc, win_target);
                        win_on = 1'b0; win_arm = 1'b0; win_done = 1'b1;
                    end
                end else if (win_arm) begin
                    win_on = 1'b1; win_cyc = 0; win_p = 0;
                end
            end else if (since == exp_len) begin
                chk(1'b0, "R3 missing pulse", since, exp_len);
            end
            if (ratio_load && int'(ratio_word) >= MIN_W) begin
                m_pend = ratio_word; m_pv = 1'b1;
            end
        end
    end

    task automatic do_load(input int w);
        @(posedge clk); #1;
        ratio_load = 1'b1; ratio_word = 19'(w);
        @(posedge clk); #1;
        ratio_load = 1'b0;
        @(negedge clk);
        chk(ratio_reject == (w < MIN_W), "R7 reject after load", int'(ratio_reject), int'(w < MIN_W));
    endtask

    task automatic wait_pulses(input int n);
        repeat (n) begin
            do @(negedge clk); while (!fb_pulse);
        end
        @(posedge clk);
    endtask

    task automatic window(input int n, input int target, input string tag);
        win_n = n; win_target = target; win_tag = tag; win_done = 1'b0; win_arm = 1'b1;
        wait (win_done);
        win_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int c;
        int len_a;
        void'($urandom(32'h1357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(fb_pulse == 1'b0, "R1 pulse low in reset", int'(fb_pulse), 0);
        chk(ratio_reject == 1'b0, "R1 reject low in reset", int'(ratio_reject), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        // R1: one priming cycle then a 4-cycle period: pulse in the 5th cycle
        c = 0;
        do begin @(negedge clk); c++; end while (!fb_pulse);
        chk(c == 5, "R1 first pulse cycle", c, 5);
        @(posedge clk);
        wait_pulses(4);
        chk(last_len == 4, "R1 reset ratio period", last_len, 4);

        // R2: 21.25 -> four periods total 85
        do_load(348160);
        wait_pulses(3);
        window(4, 85, "R2 four-period total");

        // R5: full accumulator cycle at 5.3125
        do_load(87040);
        wait_pulses(3);
        window(16384, 87040, "R5 16384-period total");

        // R6: load coinciding with the boundary
        do_load(348160);
        wait_pulses(3);
        wait_pulses(1);
        len_a = exp_len;
        repeat (len_a - 1) @(posedge clk);
        #1 ratio_load = 1'b1; ratio_word = 19'(163840);
        @(negedge clk);
        chk(fb_pulse == 1'b1, "R6 load lands in pulse cycle", int'(fb_pulse), 1);
        @(posedge clk); #1 ratio_load = 1'b0;
        wait_pulses(1);
        chk(last_len == 21 || last_len == 22, "R6 old word still governs", last_len, 21);
        wait_pulses(1);
        chk(last_len == 10, "R6 new word after one period", last_len, 10);

        // R9: two loads inside one period, the last wins
        wait_pulses(1);
        do_load(327680);
        do_load(245760);
        wait_pulses(1);
        chk(last_len == 10, "R9 current period unchanged", last_len, 10);
        wait_pulses(1);
        chk(last_len == 15, "R9 last word applied", last_len, 15);

        // R7: range limit
        do_load(55705);
        wait_pulses(2);
        chk(last_len == 15, "R7 refused word has no effect", last_len, 15);
        do_load(0);
        wait_pulses(2);
        chk(last_len == 15, "R7 zero word has no effect", last_len, 15);
        do_load(55706);
        wait_pulses(2);
        chk(last_len == 3 || last_len == 4, "R7 lowest legal word", last_len, 3);
        wait_pulses(300);

        // R8: all-ones word
        do_load(524287);
        wait_pulses(2);
        max_len = 0;
        wait_pulses(20);
        chk(max_len == 32, "R8 all-ones longest period", max_len, 32);
        chk(last_len == 31 || last_len == 32, "R8 all-ones period span", last_len, 32);

        // random loads, legal and illegal, at random gaps
        repeat (40) begin
            int w;
            if ($urandom % 4 == 0) w = int'($urandom % MIN_W);
            else w = MIN_W + int'($urandom % (524288 - MIN_W));
            do_load(w);
            repeat ($urandom % 80) @(posedge clk);
        end
        wait_pulses(3);
        finish_run();
    end
endmodule